// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets a host processor read and write a bank of byte-wide control registers over a four-wire serial link. The link has an active-low latch line that frames each transaction, a serial clock, a host-to-slave data line and a slave-to-host data line. The slave-to-host line is tri-stated. The block samples all three incoming lines with its own system clock, so the serial clock may run freely or stop between transactions. Each serial clock level must last at least 8 system clock cycles.

A transaction opens when the latch line falls. The first byte carries a 7-bit chip identifier and a direction flag. The next two bytes carry a 16-bit register address. Data bytes follow, as many as the host chooses, and the address advances by one after each of them. A write stores each completed byte. A read shifts out the register contents on the slave-to-host line. The line is driven only while a matching read is in its data phase, and it returns to high impedance when the latch is released.

The register bank is a window of DEPTH bytes at address BASE, which is 0x4000 by default. BASE must be a multiple of DEPTH. The storage is a single-write-port array with a registered read port, so it maps onto block RAM.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and whenever the latch line is high, spi_dout_en is 0 and spi_dout is high impedance. After the latch rises, spi_dout_en falls within 3 clk cycles.
- R2: A write transaction to an address inside the window stores the data byte, and a later read of that address returns it.
- R3: In the first byte, bits 7:1 are the chip identifier and bit 0 is the direction (1 = read, 0 = write). If the identifier differs from CHIP_ID (default 7'h38), nothing is written and spi_dout_en stays 0 for the whole transaction.
- R4: spi_din is sampled on rising serial clock edges, most significant bit first. The second byte is address bits 15:8 and the third byte is address bits 7:0.
- R5: After every data byte the register address increases by one, so a burst of N bytes covers N consecutive addresses.
- R6: Readback bits are launched on falling serial clock edges, most significant bit first. The first bit comes on the falling edge that follows the last address bit. spi_dout_en is 1 from that edge until the latch is released, and the data bit changes only on falling edges.
- R7: Raising the latch before a data byte is complete discards that byte, and the register keeps its previous value.
- R8: The window covers BASE to BASE+DEPTH-1 (0x4000 to 0x403F by default). A write outside the window changes no register, and a read outside it returns 0x00. This also holds when a burst runs past the end of the window.
- R9: Serial clock edges while the latch is high have no effect on registers or on the output enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_latch_n | input | 1 | Transaction frame, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial readback data, high impedance unless enabled |
| spi_dout_en | output | 1 | High while spi_dout is driven |

## Verification
Each pin passes through two synchronizer stages and an edge detector, and the register stage comes after that. A readback bit therefore appears about 3 clk cycles after the falling serial edge that launches it. The bench samples it at the end of the low half, 8 clk cycles after that edge. Writes complete about 3 clk cycles after the eighth rising edge of a data byte. The output enable clears within 3 clk cycles of the latch rising. The bench waits 16 clk cycles after the latch rises before it checks the enable or starts the next transaction, so every sample lands well after its result has settled.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [2:0] {
    PH_ID   = 3'd0,
    PH_AHI  = 3'd1,
    PH_ALO  = 3'd2,
    PH_DATA = 3'd3,
    PH_SKIP = 3'd4
  } phase_t;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic latch_n_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic din_o
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE_LVL = 3'b001;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic             sclk_d;

  assign raw = {din_i, sclk_i, latch_n_i};

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_LVL[l]}};
        else     chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign synced[l] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= synced[1];
  end

  assign sel_o  = ~synced[0];
  assign rise_o = sel_o & synced[1] & ~sclk_d;
  assign fall_o = sel_o & ~synced[1] & sclk_d;
  assign din_o  = synced[2];
endmodule

// File: rtl/spi_reg_ram.sv
module spi_reg_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic          rvalid,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;
  logic       ok_q;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= rvalid;
  end

  assign rdata = ok_q ? rd_q : 8'h00;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter logic [6:0]        CHIP_ID = 7'h38,
  parameter logic [ADDR_W-1:0] BASE    = 16'h4000,
  parameter int                AW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  input  logic [7:0]    rd_byte,
  output logic          wr_en,
  output logic [AW-1:0] idx,
  output logic [7:0]    wr_byte,
  output logic          in_range,
  output logic          dout,
  output logic          oe
);
  phase_t              phase;
  logic [2:0]          bit_cnt;
  logic [7:0]          shreg;
  logic [7:0]          nxt_byte;
  logic [6:0]          txsh;
  logic                is_read;
  logic [ADDR_W-1:0]   cur_addr;
  logic                byte_done;

  assign nxt_byte  = {shreg[6:0], din};
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign in_range  = (cur_addr[ADDR_W-1:AW] == BASE[ADDR_W-1:AW]);
  assign idx       = cur_addr[AW-1:0];
  assign wr_byte   = nxt_byte;
  assign wr_en     = byte_done && (phase == PH_DATA) && !is_read && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_ID;
      bit_cnt  <= 3'd0;
      shreg    <= 8'h00;
      txsh     <= 7'h00;
      is_read  <= 1'b0;
      cur_addr <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
    end else if (!sel) begin
      phase   <= PH_ID;
      bit_cnt <= 3'd0;
      is_read <= 1'b0;
      dout    <= 1'b0;
      oe      <= 1'b0;
    end else begin
      if (rise) begin
        shreg   <= nxt_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          case (phase)
            PH_ID: begin
              if (nxt_byte[7:1] == CHIP_ID) begin
                phase   <= PH_AHI;
                is_read <= nxt_byte[0];
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_AHI: begin
              cur_addr[15:8] <= nxt_byte;
              phase          <= PH_ALO;
            end
            PH_ALO: begin
              cur_addr[7:0] <= nxt_byte;
              phase         <= PH_DATA;
            end
            PH_DATA: cur_addr <= cur_addr + 16'd1;
            default: phase <= PH_SKIP;
          endcase
        end
      end
      if (fall && (phase == PH_DATA) && is_read) begin
        oe <= 1'b1;
        if (bit_cnt == 3'd0) begin
          dout <= rd_byte[7];
          txsh <= rd_byte[6:0];
        end else begin
          dout <= txsh[6];
          txsh <= {txsh[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter logic [6:0]  CHIP_ID     = 7'h38,
  parameter logic [15:0] BASE        = 16'h4000,
  parameter int          DEPTH       = 64,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_latch_n,
  input  logic spi_sclk,
  input  logic spi_din,
  output logic spi_dout,
  output logic spi_dout_en
);
  localparam int AW = $clog2(DEPTH);

  logic          sel;
  logic          sclk_rise;
  logic          sclk_fall;
  logic          din_s;
  logic          wr_en;
  logic [AW-1:0] reg_idx;
  logic [7:0]    wr_byte;
  logic [7:0]    rd_byte;
  logic          in_range;
  logic          dout_q;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .latch_n_i(spi_latch_n), .sclk_i(spi_sclk), .din_i(spi_din),
    .sel_o(sel), .rise_o(sclk_rise), .fall_o(sclk_fall), .din_o(din_s)
  );

  spi_frame_ctrl #(.CHIP_ID(CHIP_ID), .BASE(BASE), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .rise(sclk_rise), .fall(sclk_fall),
    .din(din_s), .rd_byte(rd_byte), .wr_en(wr_en), .idx(reg_idx),
    .wr_byte(wr_byte), .in_range(in_range), .dout(dout_q), .oe(spi_dout_en)
  );

  spi_reg_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .idx(reg_idx), .wdata(wr_byte),
    .rvalid(in_range), .rdata(rd_byte)
  );

  assign spi_dout = spi_dout_en ? dout_q : 1'bz;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic rise,
  input logic fall,
  input logic we,
  input logic dout_q,
  input logic dout_en
);
  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !dout_en);
  // R3
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> !dout_en);
  // R4
  edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));
  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> $past(fall));
  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !fall) |=> $stable(dout_q));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .rise(sclk_rise), .fall(sclk_fall),
  .we(wr_en), .dout_q(dout_q), .dout_en(spi_dout_en)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int HALF = 32;
  localparam logic [6:0] ID = 7'h38;
  // fields: [32] read, [31:16] address, [15:8] write data, [7:0] expected
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 16'h4000, 8'h12, 8'h00},
    {1'b0, 16'h4001, 8'hC6, 8'h00},
    {1'b0, 16'h403F, 8'h07, 8'h00},
    {1'b0, 16'h4010, 8'h00, 8'h00},
    {1'b1, 16'h4000, 8'h00, 8'h12},
    {1'b1, 16'h4001, 8'h00, 8'hC6},
    {1'b1, 16'h403F, 8'h00, 8'h07},
    {1'b1, 16'h4010, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic latch_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  wire  dout;
  logic dout_en;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic en_mid;

  always #2 clk = ~clk;

  spi_reg_slave u0 (
    .clk(clk), .rst(rst), .spi_latch_n(latch_n), .spi_sclk(sclk),
    .spi_din(din), .spi_dout(dout), .spi_dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      din = tx[b];
      #HALF;
      rx[b] = dout;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [6:0] id, input logic rd, input logic [15:0] addr, input int n);
    logic [7:0] junk;
    latch_n = 1'b0;
    #HALF;
    put_byte({id, rd}, junk);
    put_byte(addr[15:8], junk);
    put_byte(addr[7:0], junk);
    for (int i = 0; i < n; i++) put_byte(rd ? 8'h00 : wbuf[i], rbuf[i]);
    #HALF;
    en_mid = dout_en;
    latch_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic read1(input logic [15:0] addr, input string req, input logic [7:0] exp);
    txn(ID, 1'b1, addr, 1);
    chk(req, rbuf[0], exp);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    logic [7:0] junk;
    repeat (4) @(negedge clk);
    chk("R1 enable during reset", {7'd0, dout_en}, 8'h00);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 enable after reset", {7'd0, dout_en}, 8'h00);

    // R2 R4 table of single-byte writes then reads
    for (int v = 0; v < 8; v++) begin
      if (!VEC[v][32]) begin
        wbuf[0] = VEC[v][15:8];
        txn(ID, 1'b0, VEC[v][31:16], 1);
      end else begin
        txn(ID, 1'b1, VEC[v][31:16], 1);
        chk("R2 R4 table read", rbuf[0], VEC[v][7:0]);
      end
    end

    // R5 burst write then burst read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    txn(ID, 1'b0, 16'h4020, 4);
    txn(ID, 1'b1, 16'h4020, 4);
    chk("R5 burst byte 0", rbuf[0], 8'h11);
    chk("R5 burst byte 1", rbuf[1], 8'h22);
    chk("R5 burst byte 2", rbuf[2], 8'h33);
    chk("R5 burst byte 3", rbuf[3], 8'h44);
    chk("R6 enable during read data", {7'd0, en_mid}, 8'h01);
    chk("R1 enable after latch release", {7'd0, dout_en}, 8'h00);

    // R3 wrong chip identifier
    wbuf[0] = 8'hFF;
    txn(7'h39, 1'b0, 16'h4000, 1);
    txn(7'h39, 1'b1, 16'h4000, 1);
    chk("R3 enable on foreign read", {7'd0, en_mid}, 8'h00);
    read1(16'h4000, "R3 foreign write ignored", 8'h12);

    // R7 abort mid-byte
    latch_n = 1'b0;
    #HALF;
    put_byte({ID, 1'b0}, junk);
    put_byte(8'h40, junk);
    put_byte(8'h01, junk);
    for (int b = 0; b < 5; b++) begin
      din = 1'b1; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    #HALF;
    latch_n = 1'b1;
    #(2*HALF);
    read1(16'h4001, "R7 partial byte dropped", 8'hC6);

    // R8 outside the window
    wbuf[0] = 8'h55;
    txn(ID, 1'b0, 16'h3FFF, 1);
    wbuf[0] = 8'h66;
    txn(ID, 1'b0, 16'h4040, 1);
    read1(16'h4000, "R8 aliased write dropped", 8'h12);
    read1(16'h4040, "R8 read above window", 8'h00);
    read1(16'h3FFF, "R8 read below window", 8'h00);
    txn(ID, 1'b1, 16'h403F, 2);
    chk("R8 burst last in window", rbuf[0], 8'h07);
    chk("R8 burst past window", rbuf[1], 8'h00);

    // R9 clock activity with latch high
    din = 1'b1;
    for (int t = 0; t < 20; t++) begin
      #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    din = 1'b0;
    chk("R9 enable with idle clocking", {7'd0, dout_en}, 8'h00);
    read1(16'h4001, "R9 register untouched", 8'hC6);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule